// File: doc/BRIEF.md
# Cache-Aware Four-Core Application Placer

This block decides which of four applications runs on which of four cores. Cores 0 and 1 share last-level cache 0, and cores 2 and 3 share last-level cache 1. Each application carries a 2-bit label that describes how it uses the cache. The placer captures the labels and a replacement-mode bit when it sees a start pulse. It then runs four placement stages, one stage per clock. Each stage handles one label. When the stages are complete, the placer presents a core-to-application map and raises `done` for one cycle.

The pairing rules depend on the mode bit. Under LRU, thrashing applications are packed together so that they pollute only one cache. Under DRRIP, thrashing applications are harmless neighbours, so they are spread across the two caches. The same mix of labels can therefore give two different maps. A scheduler sets the labels, pulses `start`, and reads `core_map` when `done` is high.

Top module: `cosched_top`

## Requirements
- R1: The labels (`app_class[2a+1:2a]` for application a: 00 = core-cache-fitting, 01 = thrashing, 10 = cache-fitting, 11 = cache-friendly) and `mode` (0 = LRU, 1 = DRRIP) are captured on the edge that accepts start. Later changes to them have no effect on the map being built.
- R2: A start accepted on an edge while idle raises `busy` for four cycles. `done` is high in the fourth cycle after the accepting edge.
- R3: In the map `core_map[2c+1:2c]`, which holds the application on core c, every application appears exactly once.
- R4: Under LRU, thrashing applications are placed first, each on the lowest-numbered free core. Pairs of them therefore share a cache.
- R5: Core-cache-fitting applications go to the non-full cache that holds the fewest of them. This gives at most one per cache where possible.
- R6: Under LRU, a cache-fitting application goes beside a lone core-cache-fitting application. Failing that, it goes beside a lone fitting or thrashing application. Failing that, it goes to the lowest free core.
- R7: Under DRRIP, thrashing applications are spread. Each one goes to the non-full cache holding the fewest thrashing applications.
- R8: Under DRRIP, a cache-fitting application goes beside a core-cache-fitting or thrashing application when a cache has one free core. Otherwise it goes to the lowest free core.
- R9: Cache-friendly applications are placed last, onto the remaining free cores in ascending core order.
- R10: Within a stage, applications are placed in ascending index order. Ties between caches go to cache 0, and within a cache the lower core is used first.
- R11: `done` lasts exactly one cycle. `core_map` changes only on that cycle's edge and holds until the next completed placement.
- R12: A start pulse while `busy` is high is ignored. It neither restarts nor lengthens the placement.
- R13: After reset, `busy`, `done` and `core_map` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a placement when idle |
| mode | input | 1 | 0 = LRU caches, 1 = DRRIP caches |
| app_class | input | 8 | Two-bit label per application |
| busy | output | 1 | Placement in progress |
| done | output | 1 | One-cycle completion flag |
| core_map | output | 8 | Two-bit application index per core |

## Verification
A faulty occupancy vector or stage counter inside the placer shows up at the ports in one of two ways. Either `core_map` is not a permutation, or the map differs from the one the rules predict. Both appear in the single cycle in which `done` is high, four cycles after start. A faulty mode or label latch shows up as the map of the wrong mode. A faulty sequencer shows up as `done` arriving at the wrong cycle, or as `busy` restarting under a second pulse. The bench checks each mix under both modes wherever the rules differ, so a rule swapped between modes yields a wrong map immediately.

// File: rtl/cosched_pkg.sv
package cosched_pkg;
  localparam int NCORE   = 4;
  localparam int CPC     = 2;
  localparam int NCACHE  = NCORE / CPC;
  localparam int ID_W    = $clog2(NCORE);
  localparam int CLS_W   = 2;
  localparam int NSTAGE  = 4;
  localparam int STG_W   = $clog2(NSTAGE);
  localparam int NCLS    = 1 << CLS_W;

  localparam logic [CLS_W-1:0] CLS_CCF = 2'b00;
  localparam logic [CLS_W-1:0] CLS_THR = 2'b01;
  localparam logic [CLS_W-1:0] CLS_FIT = 2'b10;
  localparam logic [CLS_W-1:0] CLS_FRN = 2'b11;

  typedef enum logic [1:0] {RULE_PACK, RULE_SPREAD, RULE_PARTNER} rule_e;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    rule_e            rule;
    logic [NCLS-1:0]  pref_a;
    logic [NCLS-1:0]  pref_b;
  } stage_cfg_t;

  typedef logic [NCORE-1:0]       core_vec_t;
  typedef logic [NCORE*CLS_W-1:0] cls_vec_t;
  typedef logic [NCORE*ID_W-1:0]  map_vec_t;

  function automatic logic [ID_W-1:0] first_free(core_vec_t used);
    logic [ID_W-1:0] r;
    r = '0;
    for (int c = NCORE - 1; c >= 0; c--)
      if (!used[c]) r = ID_W'(c);
    return r;
  endfunction

  function automatic logic cache_has_free(core_vec_t used, int k);
    logic r;
    r = 1'b0;
    for (int j = 0; j < CPC; j++)
      if (!used[k*CPC + j]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [ID_W-1:0] free_in_cache(core_vec_t used, int k);
    logic [ID_W-1:0] r;
    r = ID_W'(k*CPC);
    for (int j = CPC - 1; j >= 0; j--)
      if (!used[k*CPC + j]) r = ID_W'(k*CPC + j);
    return r;
  endfunction

  function automatic int count_in_cache(core_vec_t used, cls_vec_t ccls, int k,
                                        logic [CLS_W-1:0] cls);
    int n;
    n = 0;
    for (int j = 0; j < CPC; j++)
      if (used[k*CPC + j] && ccls[(k*CPC + j)*CLS_W +: CLS_W] == cls) n++;
    return n;
  endfunction

  function automatic cls_vec_t core_classes(cls_vec_t app_cls, map_vec_t capp);
    cls_vec_t r;
    r = '0;
    for (int c = 0; c < NCORE; c++) begin
      int idx;
      idx = int'(capp[c*ID_W +: ID_W]);
      r[c*CLS_W +: CLS_W] = app_cls[idx*CLS_W +: CLS_W];
    end
    return r;
  endfunction

  function automatic logic [ID_W-1:0] spread_pick(core_vec_t used, cls_vec_t ccls,
                                                  logic [CLS_W-1:0] cls);
    int best;
    int best_n;
    best = -1;
    best_n = 0;
    for (int k = 0; k < NCACHE; k++) begin
      int n;
      n = count_in_cache(used, ccls, k, cls);
      if (cache_has_free(used, k) && (best < 0 || n < best_n)) begin
        best = k;
        best_n = n;
      end
    end
    if (best < 0) return first_free(used);
    return free_in_cache(used, best);
  endfunction

  function automatic logic partner_ok(core_vec_t used, cls_vec_t ccls, int k,
                                      logic [NCLS-1:0] pref);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < CPC; j++)
      if (used[k*CPC + j] && pref[ccls[(k*CPC + j)*CLS_W +: CLS_W]]) hit = 1'b1;
    return hit && cache_has_free(used, k);
  endfunction

  function automatic logic [ID_W-1:0] partner_pick(core_vec_t used, cls_vec_t ccls,
                                                   logic [NCLS-1:0] pa,
                                                   logic [NCLS-1:0] pb);
    int ka;
    int kb;
    ka = -1;
    kb = -1;
    for (int k = NCACHE - 1; k >= 0; k--) begin
      if (partner_ok(used, ccls, k, pa)) ka = k;
      if (partner_ok(used, ccls, k, pb)) kb = k;
    end
    if (ka >= 0) return free_in_cache(used, ka);
    if (kb >= 0) return free_in_cache(used, kb);
    return first_free(used);
  endfunction

  function automatic logic map_is_perm(map_vec_t m);
    logic [NCORE-1:0] seen;
    seen = '0;
    for (int c = 0; c < NCORE; c++) seen[m[c*ID_W +: ID_W]] = 1'b1;
    return &seen;
  endfunction
endpackage

// File: rtl/cosched_rules.sv
module cosched_rules
  import cosched_pkg::*;
(
  input  logic             mode_drrip,
  input  logic [STG_W-1:0] stage,
  output stage_cfg_t       cfg
);
  localparam logic [NCLS-1:0] M_CCF = NCLS'(1) << CLS_CCF;
  localparam logic [NCLS-1:0] M_THR = NCLS'(1) << CLS_THR;
  localparam logic [NCLS-1:0] M_FIT = NCLS'(1) << CLS_FIT;

  always_comb begin
    cfg = '{cls: CLS_FRN, rule: RULE_PACK, pref_a: '0, pref_b: '0};
    case (stage)
      STG_W'(0): begin
        cfg.cls  = CLS_THR;
        cfg.rule = mode_drrip ? RULE_SPREAD : RULE_PACK;
      end
      STG_W'(1): begin
        cfg.cls  = CLS_CCF;
        cfg.rule = RULE_SPREAD;
      end
      STG_W'(2): begin
        cfg.cls    = CLS_FIT;
        cfg.rule   = RULE_PARTNER;
        cfg.pref_a = mode_drrip ? (M_CCF | M_THR) : M_CCF;
        cfg.pref_b = mode_drrip ? '0 : (M_FIT | M_THR);
      end
      default: begin
        cfg.cls  = CLS_FRN;
        cfg.rule = RULE_PACK;
      end
    endcase
  end
endmodule

// File: rtl/cosched_stage.sv
module cosched_stage
  import cosched_pkg::*;
(
  input  cls_vec_t   app_cls,
  input  stage_cfg_t cfg,
  input  core_vec_t  placed_in,
  input  core_vec_t  used_in,
  input  map_vec_t   capp_in,
  output core_vec_t  placed_out,
  output core_vec_t  used_out,
  output map_vec_t   capp_out
);
  always_comb begin
    core_vec_t       placed;
    core_vec_t       used;
    map_vec_t        capp;
    cls_vec_t        ccls;
    logic [ID_W-1:0] pick;
    placed = placed_in;
    used   = used_in;
    capp   = capp_in;
    ccls   = '0;
    pick   = '0;
    for (int a = 0; a < NCORE; a++) begin
      if (!placed[a] && app_cls[a*CLS_W +: CLS_W] == cfg.cls) begin
        ccls = core_classes(app_cls, capp);
        case (cfg.rule)
          RULE_SPREAD:  pick = spread_pick(used, ccls, cfg.cls);
          RULE_PARTNER: pick = partner_pick(used, ccls, cfg.pref_a, cfg.pref_b);
          default:      pick = first_free(used);
        endcase
        placed[a] = 1'b1;
        used[pick] = 1'b1;
        capp[int'(pick)*ID_W +: ID_W] = ID_W'(a);
      end
    end
    placed_out = placed;
    used_out   = used;
    capp_out   = capp;
  end
endmodule

// File: rtl/cosched_top.sv
module cosched_top
  import cosched_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mode,
  input  logic [NCORE*CLS_W-1:0] app_class,
  output logic                   busy,
  output logic                   done,
  output logic [NCORE*ID_W-1:0]  core_map
);
  logic             run_q;
  logic [STG_W-1:0] stage_q;
  logic             mode_q;
  cls_vec_t         cls_q;
  core_vec_t        placed_q, placed_nx;
  core_vec_t        used_q, used_nx;
  map_vec_t         capp_q, capp_nx;
  stage_cfg_t       cfg;

  logic accept_evt, ignore_evt, stage_last, finish_evt;
  assign accept_evt = start && !run_q;
  assign ignore_evt = start && run_q;
  assign stage_last = (stage_q == STG_W'(NSTAGE - 1));
  assign finish_evt = run_q && stage_last;

  cosched_rules u_rules (
    .mode_drrip(mode_q),
    .stage     (stage_q),
    .cfg       (cfg)
  );

  cosched_stage u_stage (
    .app_cls   (cls_q),
    .cfg       (cfg),
    .placed_in (placed_q),
    .used_in   (used_q),
    .capp_in   (capp_q),
    .placed_out(placed_nx),
    .used_out  (used_nx),
    .capp_out  (capp_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      stage_q  <= '0;
      mode_q   <= 1'b0;
      cls_q    <= '0;
      placed_q <= '0;
      used_q   <= '0;
      capp_q   <= '0;
      done     <= 1'b0;
      core_map <= '0;
    end else begin
      done <= 1'b0;
      if (accept_evt) begin
        run_q    <= 1'b1;
        stage_q  <= '0;
        mode_q   <= mode;
        cls_q    <= app_class;
        placed_q <= '0;
        used_q   <= '0;
        capp_q   <= '0;
      end else if (run_q) begin
        placed_q <= placed_nx;
        used_q   <= used_nx;
        capp_q   <= capp_nx;
        if (stage_last) begin
          run_q    <= 1'b0;
          done     <= 1'b1;
          core_map <= capp_nx;
        end else begin
          stage_q <= stage_q + STG_W'(1);
        end
      end
    end
  end

  assign busy = run_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  map_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> map_is_perm(core_map));
  // R3
  all_placed_chk: assert property (@(posedge clk) disable iff (!rst_n) finish_evt |-> (&placed_nx && &used_nx));
  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R2
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R12
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_evt && !stage_last) |=> (busy && stage_q == $past(stage_q) + STG_W'(1)));
  // R11
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(core_map));
endmodule

// File: tb/cosched_top_tb.sv
module cosched_top_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] app_class = '0;
  logic       busy, done;
  logic [7:0] core_map;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cosched_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .app_class(app_class), .busy(busy), .done(done), .core_map(core_map)
  );

  typedef struct packed {
    logic       m;
    logic [7:0] cls;
    logic [7:0] exp;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 8'b00_10_01_01, 8'b10_11_01_00, 4'd4},
    '{1'b1, 8'b00_10_01_01, 8'b10_01_11_00, 4'd7},
    '{1'b0, 8'b11_11_00_00, 8'b11_01_10_00, 4'd5},
    '{1'b1, 8'b11_11_00_00, 8'b11_01_10_00, 4'd9},
    '{1'b0, 8'b01_01_10_10, 8'b01_00_11_10, 4'd6},
    '{1'b1, 8'b01_01_10_10, 8'b01_11_00_10, 4'd8},
    '{1'b0, 8'b11_11_11_11, 8'b11_10_01_00, 4'd9},
    '{1'b0, 8'b00_00_00_00, 8'b11_01_10_00, 4'd5},
    '{1'b0, 8'b01_01_01_01, 8'b11_10_01_00, 4'd4},
    '{1'b1, 8'b01_01_01_01, 8'b11_01_10_00, 4'd7},
    '{1'b0, 8'b01_11_00_10, 8'b10_00_01_11, 4'd10},
    '{1'b1, 8'b01_11_00_10, 8'b10_00_01_11, 4'd10},
    '{1'b0, 8'b00_10_00_10, 8'b10_11_00_01, 4'd6},
    '{1'b0, 8'b11_00_01_10, 8'b11_00_10_01, 4'd10},
    '{1'b0, 8'b01_10_10_01, 8'b10_01_11_00, 4'd6},
    '{1'b1, 8'b01_10_10_01, 8'b10_11_01_00, 4'd8}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_perm(logic [7:0] m);
    logic [3:0] seen = '0;
    for (int c = 0; c < 4; c++) seen[m[c*2 +: 2]] = 1'b1;
    return seen == 4'hF;
  endfunction

  // Drives one placement; lat counts negedges after the accepting edge until done.
  task automatic run_place(input logic m, input logic [7:0] cls, input int poke,
                           output logic [7:0] map, output int lat);
    @(negedge clk);
    start = 1'b1; mode = m; app_class = cls;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (lat == 1 && poke == 1) begin
        start = 1'b1; app_class = ~cls; mode = ~m;
      end else if (lat == 2 && poke != 0) begin
        start = 1'b0; app_class = 8'h5A; mode = ~m;
      end
    end
    map = core_map;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] map;
    int lat;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(busy == 1'b0, "R13", busy, 0);
    check(done == 1'b0, "R13", done, 0);
    check(core_map == 8'h00, "R13", core_map, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      run_place(VEC[i].m, VEC[i].cls, 0, map, lat);
      check(map == VEC[i].exp, tag_name(VEC[i].tag), map, VEC[i].exp);
      check(is_perm(map), "R3", map, 8'hE4);
      check(lat == 4, "R2", lat, 4);
      @(negedge clk);
      check(done == 1'b0, "R11", done, 0);
    end

    // R12: second start during busy, then R1: inputs changed during busy
    run_place(1'b0, 8'b00_10_01_01, 1, map, lat);
    check(lat == 4, "R12", lat, 4);
    check(map == 8'b10_11_01_00, "R12", map, 8'b10_11_01_00);
    check(map == 8'b10_11_01_00, "R1", map, 8'b10_11_01_00);
    run_place(1'b1, 8'b01_10_10_01, 2, map, lat);
    check(map == 8'b10_11_01_00, "R1", map, 8'b10_11_01_00);
    check(lat == 4, "R1", lat, 4);

    // R11: map holds while idle with changing inputs and no start
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      app_class = 8'(k * 37); mode = k[0];
      check(core_map == 8'b10_11_01_00, "R11", core_map, 8'b10_11_01_00);
      check(busy == 1'b0, "R11", busy, 0);
    end

    // R13 again: reset clears a held map
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(core_map == 8'h00, "R13", core_map, 0);
    rst_n = 1'b1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule